// File: doc/BRIEF.md
# Burst Address Sequence Generator

This block supplies the word address for a synchronous burst memory. A full address is captured when an address strobe is sampled on a rising clock edge. There are two strobes, one from a processor and one from a cache controller, and both are qualified by a chip enable. After the capture, the block produces the following beats of a four-beat burst internally. Only the two least significant address bits change. They step once in each cycle where the advance input is high, and the upper bits keep their captured value.

A static order-select input chooses between two wrap orders. The linear order counts the low bits up by one, modulo four, from the captured start. The interleaved order XORs the captured start with a beat count of 0, 1, 2, 3. The output is registered state, so it changes just after the clock edge that samples the strobe or the advance. The memory array, the data path and the output drivers are outside this block.

Top module: `burst_addr_seq`

## Requirements
- R1: While rst_n is low, and after it is released with no strobe yet taken, word_addr is zero.
- R2: When chip_en is high and cpu_strobe or ctl_strobe is high at a rising edge, word_addr equals addr_in from that edge onward. The beat count restarts at zero.
- R3: When chip_en is low, neither strobe has any effect, and word_addr keeps its value unless advance is high.
- R4: An advance changes only word_addr[1:0]. The upper bits word_addr[ADDR_W-1:2] change only on a taken strobe.
- R5: With order_sel low (linear), beat k of a burst gives word_addr[1:0] = (start + k) mod 4. A start of 1 gives 1, 2, 3, 0.
- R6: With order_sel high (interleaved), beat k gives word_addr[1:0] = start XOR k. A start of 1 gives 1, 0, 3, 2.
- R7: When a taken strobe and advance are high at the same edge, the strobe wins. The new address is loaded and the beat count is zero.
- R8: In a cycle with no taken strobe and advance low, word_addr holds its value.
- R9: Advances past the fourth beat keep counting modulo 4. The fifth beat returns to the start value in both orders.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_strobe | input | 1 | Processor address strobe, active high |
| ctl_strobe | input | 1 | Cache-controller address strobe, active high |
| chip_en | input | 1 | Chip enable that qualifies both strobes, active high |
| advance | input | 1 | Steps the burst beat by one when high |
| order_sel | input | 1 | 0 = linear wrap order, 1 = interleaved wrap order |
| addr_in | input | ADDR_W | Address captured on a taken strobe |
| word_addr | output | ADDR_W | Current word address to the memory array |

## Verification
A load and an advance can fall in the same cycle. So can a strobe and a deasserted chip enable. The bench drives a strobe and advance together in the middle of a burst, and the next word_addr must be the new address with a beat count of zero, not the old burst's next beat. The random phase draws strobe, advance and chip enable independently, so these collisions recur often. A bench model that applies load-over-advance priority judges every cycle, both at the full address and at the upper bits alone.

// File: rtl/burst_seq_pkg.sv
`timescale 1ns/1ps
package burst_seq_pkg;
    // The burst counter covers the low address bits only: four beats.
    localparam int BEAT_W = 2;
    localparam int BEATS  = 1 << BEAT_W;

    typedef logic [BEAT_W-1:0] beat_t;

    typedef enum logic {
        ORDER_LINEAR = 1'b0,
        ORDER_XOR    = 1'b1
    } order_e;

    // Position inside a burst: captured start bits and beats taken so far.
    typedef struct packed {
        beat_t start;
        beat_t beat;
    } burst_pos_t;
endpackage

// File: rtl/burst_strobe_qual.sv
`timescale 1ns/1ps
module burst_strobe_qual (
    input  logic cpu_strobe,
    input  logic ctl_strobe,
    input  logic chip_en,
    output logic load
);
    // Either strobe starts a burst, but only while the chip is enabled.
    always_comb begin
        load = chip_en & (cpu_strobe | ctl_strobe);
    end
endmodule

// File: rtl/burst_order_map.sv
`timescale 1ns/1ps
module burst_order_map
    import burst_seq_pkg::*;
(
    input  beat_t  start,
    input  beat_t  beat,
    input  order_e order,
    output beat_t  low_bits
);
    beat_t lin_bits;
    beat_t xor_bits;

    always_comb begin
        lin_bits = beat_t'(start + beat);
        xor_bits = start ^ beat;
        low_bits = (order == ORDER_XOR) ? xor_bits : lin_bits;
    end
endmodule

// File: rtl/burst_addr_seq.sv
`timescale 1ns/1ps
module burst_addr_seq
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_strobe,
    input  logic              ctl_strobe,
    input  logic              chip_en,
    input  logic              advance,
    input  logic              order_sel,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] word_addr
);
    localparam int UPPER_W = ADDR_W - BEAT_W;

    typedef struct packed {
        logic [UPPER_W-1:0] upper;
        burst_pos_t         pos;
    } seq_state_t;

    seq_state_t st_d;
    seq_state_t st_q;
    logic       load;
    beat_t      low_bits;
    order_e     order;

    assign order = order_e'(order_sel);

    burst_strobe_qual u_qual (
        .cpu_strobe (cpu_strobe),
        .ctl_strobe (ctl_strobe),
        .chip_en    (chip_en),
        .load       (load)
    );

    // Next state: a taken strobe has priority over advance.
    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.upper     = addr_in[ADDR_W-1:BEAT_W];
            st_d.pos.start = addr_in[BEAT_W-1:0];
            st_d.pos.beat  = '0;
        end else if (advance) begin
            st_d.pos.beat  = beat_t'(st_q.pos.beat + 1'b1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    burst_order_map u_map (
        .start    (st_q.pos.start),
        .beat     (st_q.pos.beat),
        .order    (order),
        .low_bits (low_bits)
    );

    assign word_addr = {st_q.upper, low_bits};
endmodule

// File: rtl/burst_addr_seq_chk.sv
`timescale 1ns/1ps
module burst_addr_seq_chk
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W = 18
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_strobe,
    input logic              ctl_strobe,
    input logic              chip_en,
    input logic              advance,
    input logic              order_sel,
    input logic [ADDR_W-1:0] addr_in,
    input logic [ADDR_W-1:0] word_addr
);
    logic taken;
    assign taken = chip_en && (cpu_strobe || ctl_strobe);

    AST_LOAD_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        taken |=> word_addr == $past(addr_in)); // R2

    AST_LOAD_BEATS_ADV: assert property (@(posedge clk) disable iff (!rst_n)
        (taken && advance) |=> word_addr == $past(addr_in)); // R7

    AST_DISABLED_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
        (!chip_en && (cpu_strobe || ctl_strobe) && !advance)
        |=> (!$stable(order_sel) || $stable(word_addr))); // R3

    AST_UPPER_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        !taken |=> word_addr[ADDR_W-1:BEAT_W] == $past(word_addr[ADDR_W-1:BEAT_W])); // R4

    AST_LINEAR_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (!taken && advance && !order_sel)
        |=> (!$stable(order_sel) ||
             word_addr[BEAT_W-1:0] == beat_t'($past(word_addr[BEAT_W-1:0]) + 1'b1))); // R5

    AST_XOR_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
        (!taken && advance && order_sel)
        |=> (!$stable(order_sel) ||
             word_addr[BEAT_W-1:0] != $past(word_addr[BEAT_W-1:0]))); // R6

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!taken && !advance) |=> (!$stable(order_sel) || $stable(word_addr))); // R8
endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sim_burst_addr_seq.sv
`timescale 1ns/1ps
module sim_burst_addr_seq;
    localparam int AW = 18;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cpu_strobe = 1'b0;
    logic          ctl_strobe = 1'b0;
    logic          chip_en = 1'b0;
    logic          advance = 1'b0;
    logic          order_sel = 1'b0;
    logic [AW-1:0] addr_in = '0;
    logic [AW-1:0] word_addr;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    logic [AW-3:0] m_upper = '0;
    logic [1:0]    m_start = '0;
    logic [1:0]    m_beat  = '0;

    always #10 clk = ~clk;

    burst_addr_seq #(.ADDR_W(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .cpu_strobe(cpu_strobe), .ctl_strobe(ctl_strobe),
        .chip_en(chip_en), .advance(advance), .order_sel(order_sel),
        .addr_in(addr_in), .word_addr(word_addr)
    );

    function automatic logic [AW-1:0] model_addr(input logic mode);
        logic [1:0] lo;
        lo = mode ? (m_start ^ m_beat) : 2'(m_start + m_beat);
        return {m_upper, lo};
    endfunction

    task automatic check(input string tag, input logic [AW-1:0] got, input logic [AW-1:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s: actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    // One cycle: drive at negedge, update model per requirements, compare after edge.
    task automatic cyc(input logic cpu, input logic ctl, input logic ce, input logic adv,
                       input logic mode, input logic [AW-1:0] a, input string tag);
        logic [AW-3:0] up_before;
        @(negedge clk);
        cpu_strobe = cpu; ctl_strobe = ctl; chip_en = ce; advance = adv;
        order_sel = mode; addr_in = a;
        up_before = m_upper;
        @(posedge clk);
        #2;
        if (ce && (cpu || ctl)) begin
            m_upper = a[AW-1:2]; m_start = a[1:0]; m_beat = 2'd0;
        end else if (adv) begin
            m_beat = 2'(m_beat + 1'b1);
        end
        check(tag, word_addr, model_addr(mode));
        if (adv && !(ce && (cpu || ctl)))
            check("R4 upper bits", {word_addr[AW-1:2], 2'b00}, {up_before, 2'b00});
    endtask

    initial begin
        #(20 * 100000);
        failures++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic [31:0] seed;
        seed = $urandom(32'h5EED_0042);
        #35;
        check("R1 in reset", word_addr, '0);
        rst_n = 1'b1;
        cyc(0, 0, 1, 0, 0, 18'h2AAA5, "R1 after release");

        // Linear from start 1: 1,2,3,0 then wrap to 1
        cyc(1, 0, 1, 0, 0, 18'h12345, "R2 cpu load");
        cyc(0, 0, 1, 1, 0, '0, "R5 beat1");
        cyc(0, 0, 1, 1, 0, '0, "R5 beat2");
        cyc(0, 0, 1, 1, 0, '0, "R5 beat3");
        cyc(0, 0, 1, 1, 0, '0, "R9 linear wrap");
        cyc(0, 0, 1, 0, 0, 18'h3FFFF, "R8 hold");

        // Interleaved from start 1: 1,0,3,2 then wrap
        cyc(0, 1, 1, 0, 1, 18'h0ABC1, "R2 ctl load");
        cyc(0, 0, 0, 1, 1, '0, "R6 beat1");
        cyc(0, 0, 1, 1, 1, '0, "R6 beat2");
        cyc(0, 0, 1, 1, 1, '0, "R6 beat3");
        cyc(0, 0, 1, 1, 1, '0, "R9 xor wrap");

        // Disabled chip ignores both strobes
        cyc(1, 0, 0, 0, 1, 18'h3C3C3, "R3 cpu ignored");
        cyc(0, 1, 0, 0, 1, 18'h01010, "R3 ctl ignored");
        cyc(1, 1, 0, 1, 1, 18'h22222, "R3 ignored with advance");

        // Strobe and advance together mid-burst
        cyc(0, 0, 1, 1, 0, '0, "R5 step");
        cyc(1, 0, 1, 1, 0, 18'h1FFFE, "R7 load wins");
        cyc(0, 0, 1, 1, 0, '0, "R7 restart beat1");

        // Constrained random
        for (int i = 0; i < 600; i++) begin
            logic cpu, ctl, ce, adv, mode;
            logic [AW-1:0] a;
            string tag;
            cpu  = ($urandom % 5) == 0;
            ctl  = ($urandom % 6) == 0;
            ce   = ($urandom % 4) != 0;
            adv  = ($urandom % 3) != 0;
            mode = (i / 100) % 2 == 1;
            a    = AW'($urandom);
            if (ce && (cpu || ctl)) tag = adv ? "R7 rand" : "R2 rand";
            else if (cpu || ctl)    tag = "R3 rand";
            else if (adv)           tag = mode ? "R6 rand" : "R5 rand";
            else                    tag = "R8 rand";
            cyc(cpu, ctl, ce, adv, mode, a, tag);
        end
        finish_run();
    end
endmodule